// File: doc/BRIEF.md
# Bit-Serial Word Timing and Microstep Sequencer

This block provides the timebase and microprogram stepping for a processor that handles its data one bit at a time. It divides the master clock into a single-cycle bit enable at a slow bit rate. While the run input is low, the bit enable is suppressed and every counter holds its value. A bit index steps through the eighteen bit positions of a short word. That index serves as the low-order address for main memory and for the register-storage memories.

One microinstruction is executed per short word. At the last bit position of the word, the 4-bit microstep counter either moves forward by one or loads a branch target. At the same moment the opcode is captured. The microcode address is the captured opcode joined with the microstep number, so this address does not change at any point during a word.

Top module: `bitser_seq`

## Requirements
- R1: While run is high, bit_en is high for exactly one master clock in every DIV master clocks. The default DIV of 250 gives 0.5 MHz from a 125 MHz master clock.
- R2: While run is low, bit_en stays low, and bit_idx, uaddr and the divider phase all hold.
- R3: bit_idx advances by one on each bit_en. From 17 it returns to 0.
- R4: The microstep counter (uaddr bits [3:0]) changes only on a bit_en that occurs while bit_idx is 17.
- R5: At that word boundary with br_req low, the microstep counter increments by one.
- R6: At that word boundary with br_req high, the microstep counter loads br_tgt.
- R7: uaddr is formed as the registered opcode in bits [OPW+3:4] and the microstep counter in bits [3:0].
- R8: op_in is captured only at the word boundary. A change of op_in in the middle of a word has no effect on uaddr until the next boundary.
- R9: An increment from microstep 15 wraps the counter to 0.
- R10: eow is high exactly while bit_idx is 17.
- R11: A synchronous reset clears bit_idx, the microstep counter, the registered opcode and the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Run control; gates the bit enable |
| op_in | input | OPW | Opcode of the current instruction |
| br_req | input | 1 | Microbranch request, sampled at the word boundary |
| br_tgt | input | 4 | Microbranch target step |
| bit_idx | output | 5 | Current bit position, 0 to 17 |
| bit_en | output | 1 | One-clock bit-time enable |
| uaddr | output | OPW+4 | Microcode ROM address |
| eow | output | 1 | End-of-word indication, high during bit 17 |

## Verification
The assertions check the following on every cycle: the gating by run and the hold of all state while stopped, the single-cycle width of bit_en, the bit index step and wrap, and the rule that the microaddress moves only at a word boundary. They also check that a branch loads its target at that boundary. Only the bench scenarios can show the exact DIV-cycle spacing of bit_en, the wrap from step 15 to 0, and that an opcode changed mid-word appears only at the next word. Those scenarios also confirm the reset values at the ports.

// File: rtl/bitser_seq.sv
module bitser_seq #(
  parameter int DIV  = 250,
  parameter int BITS = 18,
  parameter int OPW  = 6,
  parameter int STW  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [OPW-1:0]     op_in,
  input  logic               br_req,
  input  logic [STW-1:0]     br_tgt,
  output logic [4:0]         bit_idx,
  output logic               bit_en,
  output logic [OPW+STW-1:0] uaddr,
  output logic               eow
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
  localparam logic [4:0]    BIT_LAST = 5'(BITS - 1);

  logic [DW-1:0]  div_q;
  logic [4:0]     bit_q;
  logic [STW-1:0] step_q;
  logic [OPW-1:0] op_q;
  logic           wrap;

  assign bit_en  = run && (div_q == DIV_LAST);
  assign eow     = (bit_q == BIT_LAST);
  assign wrap    = bit_en && eow;
  assign bit_idx = bit_q;
  assign uaddr   = {op_q, step_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= '0;
    end else if (bit_en) begin
      bit_q <= eow ? '0 : bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      op_q   <= '0;
    end else if (wrap) begin
      step_q <= br_req ? br_tgt : step_q + 1'b1;
      op_q   <= op_in;
    end
  end
endmodule

// File: rtl/bitser_seq_chk.sv
module bitser_seq_chk #(
  parameter int BITS = 18,
  parameter int OPW  = 6,
  parameter int STW  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               run,
  input logic               br_req,
  input logic [STW-1:0]     br_tgt,
  input logic [4:0]         bit_idx,
  input logic               bit_en,
  input logic [OPW+STW-1:0] uaddr,
  input logic               eow
);
  localparam logic [4:0] LAST = 5'(BITS - 1);

  p_gate_r2: assert property (@(posedge clk) disable iff (rst) !run |-> !bit_en);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(bit_idx) && $stable(uaddr)));
  p_pulse_r1: assert property (@(posedge clk) disable iff (rst) bit_en |=> !bit_en);
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (bit_en && bit_idx != LAST) |=> (bit_idx == $past(bit_idx) + 5'd1));
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (bit_en && bit_idx == LAST) |=> (bit_idx == 5'd0));
  p_range_r3: assert property (@(posedge clk) disable iff (rst) bit_idx <= LAST);
  p_still_r4: assert property (@(posedge clk) disable iff (rst)
    !(bit_en && bit_idx == LAST) |=> $stable(uaddr));
  p_branch_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_en && bit_idx == LAST && br_req) |=> (uaddr[STW-1:0] == $past(br_tgt)));
  p_inc_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_en && bit_idx == LAST && !br_req) |=>
      (uaddr[STW-1:0] == $past(uaddr[STW-1:0]) + 1'b1));
  p_eow_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(eow) |-> $past(bit_en));
endmodule

bind bitser_seq bitser_seq_chk #(.BITS(BITS), .OPW(OPW), .STW(STW)) i_chk (
  .clk(clk), .rst(rst), .run(run), .br_req(br_req), .br_tgt(br_tgt),
  .bit_idx(bit_idx), .bit_en(bit_en), .uaddr(uaddr), .eow(eow)
);

// File: tb/test_bitser_seq.sv
module test_bitser_seq;
  localparam int DIV = 4;
  localparam int OPW = 6;

  logic clk = 1'b0;
  logic rst, run, br_req;
  logic [OPW-1:0] op_in;
  logic [3:0] br_tgt;
  logic [4:0] bit_idx;
  logic bit_en, eow;
  logic [OPW+3:0] uaddr;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  bitser_seq #(.DIV(DIV), .BITS(18), .OPW(OPW), .STW(4)) i_bitser_seq (
    .clk(clk), .rst(rst), .run(run), .op_in(op_in), .br_req(br_req),
    .br_tgt(br_tgt), .bit_idx(bit_idx), .bit_en(bit_en), .uaddr(uaddr), .eow(eow)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_bit();
    @(negedge clk);
    while (!bit_en) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic to_bit(input int b);
    while (bit_idx != 5'(b)) next_bit();
  endtask

  task automatic t_reset();
    rst = 1'b1; run = 1'b1; op_in = 6'h2A; br_req = 1'b0; br_tgt = '0;
    repeat (3) @(negedge clk);
    chk(bit_idx == 0, "R11 bit_idx", bit_idx, 0);
    chk(uaddr == 0, "R11 uaddr", uaddr, 0);
    chk(!bit_en, "R11 bit_en", bit_en, 0);
    rst = 1'b0;
  endtask

  task automatic t_divide();
    int n = 0;
    int w = 0;
    @(negedge clk);
    while (!bit_en) @(negedge clk);
    @(negedge clk);
    while (!bit_en) begin n++; @(negedge clk); end
    while (bit_en) begin w++; @(negedge clk); end
    chk(n + 1 == DIV, "R1 spacing", n + 1, DIV);
    chk(w == 1, "R1 width", w, 1);
  endtask

  task automatic t_count();
    to_bit(0);
    for (int b = 1; b < 18; b++) begin
      chk(!eow, "R10 eow low", eow, 0);
      next_bit();
      chk(bit_idx == 5'(b), "R3 step", bit_idx, b);
    end
    chk(eow, "R10 eow high", eow, 1);
    next_bit();
    chk(bit_idx == 0, "R3 wrap", bit_idx, 0);
  endtask

  task automatic t_step_and_op();
    logic [3:0] s0;
    to_bit(1);
    s0 = uaddr[3:0];
    op_in = 6'h15;
    to_bit(17);
    chk(uaddr[3:0] == s0, "R4 no mid-word change", uaddr[3:0], s0);
    chk(uaddr[9:4] == 6'h2A, "R8 opcode held", uaddr[9:4], 6'h2A);
    next_bit();
    chk(uaddr[3:0] == s0 + 4'd1, "R5 increment", uaddr[3:0], s0 + 4'd1);
    chk(uaddr == {6'h15, 4'(s0 + 4'd1)}, "R7 concat", uaddr, {6'h15, 4'(s0 + 4'd1)});
  endtask

  task automatic t_branch_wrap();
    to_bit(17);
    br_req = 1'b1; br_tgt = 4'd15;
    next_bit();
    br_req = 1'b0;
    chk(uaddr[3:0] == 4'd15, "R6 branch", uaddr[3:0], 15);
    to_bit(17);
    next_bit();
    chk(uaddr[3:0] == 4'd0, "R9 wrap", uaddr[3:0], 0);
  endtask

  task automatic t_run();
    logic [4:0] b0;
    logic [9:0] u0;
    int seen = 0;
    to_bit(17);
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    b0 = bit_idx; u0 = uaddr;
    br_req = 1'b1; br_tgt = 4'd3;
    repeat (DIV * 5) begin
      @(negedge clk);
      if (bit_en) seen++;
    end
    br_req = 1'b0;
    chk(seen == 0, "R2 no enable", seen, 0);
    chk(bit_idx == b0, "R2 bit hold", bit_idx, b0);
    chk(uaddr == u0, "R2 uaddr hold", uaddr, u0);
    run = 1'b1;
    next_bit();
    chk(bit_idx == 0, "R2 resume", bit_idx, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_divide();
        t_count();
        t_step_and_op();
        t_branch_wrap();
        t_run();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule